// File: doc/BRIEF.md
# Debounced Push-Button Toggle Switch

This block turns one mechanical push-button, wired active low and subject to contact bounce, into a clean ON/OFF level. Each press the block accepts flips that level once. The button is never looked at on every clock. It is sampled only on cycles where a slow periodic strobe (`tick`) is high, typically one strobe per millisecond. A press counts only when a low sample is followed, a fixed number of strobes later, by a second low sample.

Once a press is accepted, the block stops looking at the button for a hold-off window that is also measured in strobes. A user who keeps a finger on the button while watching the equipment react therefore does not flip it straight back. The raw pin goes through a multi-flop synchroniser before any sampling takes place. Each accepted press also produces a one-cycle `press_event` pulse, so downstream logic can count presses.

Top module: `toggle_switch_ctrl`

## Requirements
- R1: The button counts as pressed when `btn_n` is 0. It passes through `SYNC_STAGES` (default 2) clocked flops and is examined only on cycles with `tick` high. A low level held for any number of cycles without a strobe has no effect, and a strobe that arrives before the synchroniser has carried the new level sees the old level.
- R2: A strobe that finds the button pressed while the block is idle starts a confirmation. The strobe that is `CONFIRM_TICKS` strobes later (default 100) takes the confirming sample, and the output toggles on that strobe's clock edge if this sample also reads pressed.
- R3: On the edge where a press is accepted, a hold-off of `BLOCK_TICKS` strobes (default 1000) starts. Every button level and change during the hold-off is ignored. The hold-off ends on its `BLOCK_TICKS`-th strobe.
- R4: Synchronous active-high `rst` forces `sw_on` to 0 (OFF) and `press_event` to 0, and discards any confirmation or hold-off in progress. `sw_on` stays OFF until the first accepted press.
- R5: Each accepted press inverts `sw_on`, so alternate presses turn it ON and OFF.
- R6: `press_event` is high for exactly one clock cycle per accepted press, in the same cycle in which `sw_on` takes its new value. `sw_on` never changes in any other cycle outside reset.
- R7: If the confirming sample reads released, the block returns to idle without toggling and without starting a hold-off, so the next pressed strobe starts a fresh confirmation at once.
- R8: If the button is still held when a hold-off ends, the next strobe starts a new confirmation. A continuous hold therefore toggles again only after at least `BLOCK_TICKS + CONFIRM_TICKS + 1` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Periodic sampling strobe, one clock cycle wide |
| btn_n | input | 1 | Raw push-button level, 0 while pressed |
| sw_on | output | 1 | Toggle state, 1 = ON |
| press_event | output | 1 | One-cycle pulse on each accepted press |

## Verification
The hardest situation to reach from the ports is a strobe landing while the synchroniser is still carrying a fresh edge, because only a strobe in that narrow window shows whether the button is sampled before or after synchronisation. The bench changes `btn_n` and raises `tick` on the same falling clock edge. It then checks that one extra strobe is needed before the toggle. Glitches inside the hold-off, a confirmation that fails at its last sample, and a reset issued halfway through a confirmation are produced by stepping the strobe one pulse at a time from the bench.

// File: rtl/toggle_sw_pkg.sv
package toggle_sw_pkg;

    // Control states of the press qualifier
    typedef enum logic [1:0] {
        TSW_IDLE    = 2'd0,
        TSW_CONFIRM = 2'd1,
        TSW_HOLDOFF = 2'd2
    } tsw_state_e;

    // Registered outputs travel together
    typedef struct packed {
        logic on;
        logic pulse;
    } tsw_out_t;

    localparam tsw_out_t TSW_OUT_RESET = '{on: 1'b0, pulse: 1'b0};

    function automatic int unsigned tsw_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold values 0..limit, never below one
    function automatic int unsigned tsw_cnt_width(input int unsigned limit);
        int unsigned w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/tsw_sync.sv
module tsw_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned N = (STAGES < 1) ? 1 : STAGES;

    logic [N-1:0] chain;

    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RESET_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RESET_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[N-1];
endmodule

// File: rtl/tsw_interval_timer.sv
module tsw_interval_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic [W:0]   next_cnt;

    assign next_cnt = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    // Asserted on the step that brings the count up to the limit
    assign expire   = step && (next_cnt == {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (step)    cnt <= next_cnt[W-1:0];
    end
endmodule

// File: rtl/tsw_fsm.sv
module tsw_fsm
    import toggle_sw_pkg::*;
#(
    parameter int unsigned W             = 8,
    parameter int unsigned CONFIRM_TICKS = 3,
    parameter int unsigned BLOCK_TICKS   = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         pressed,
    input  logic         expire,
    output logic         timer_clear,
    output logic         timer_step,
    output logic [W-1:0] timer_limit,
    output tsw_out_t     out
);
    localparam logic [W-1:0] LIM_CONFIRM = W'(tsw_max(CONFIRM_TICKS, 1));
    localparam logic [W-1:0] LIM_BLOCK   = W'(tsw_max(BLOCK_TICKS, 1));

    tsw_state_e state, state_nx;
    tsw_out_t   out_nx;

    always_comb begin
        state_nx  = state;
        out_nx    = '{on: out.on, pulse: 1'b0};
        unique case (state)
            TSW_IDLE: begin
                if (tick && pressed) state_nx = TSW_CONFIRM;
            end
            TSW_CONFIRM: begin
                if (expire) begin
                    if (pressed) begin
                        state_nx     = TSW_HOLDOFF;
                        out_nx.on    = !out.on;
                        out_nx.pulse = 1'b1;
                    end else begin
                        state_nx = TSW_IDLE;
                    end
                end
            end
            TSW_HOLDOFF: begin
                if (expire) state_nx = TSW_IDLE;
            end
            default: state_nx = TSW_IDLE;
        endcase
    end

    assign timer_step  = tick && (state != TSW_IDLE);
    assign timer_clear = (state == TSW_IDLE) || expire;
    assign timer_limit = (state == TSW_HOLDOFF) ? LIM_BLOCK : LIM_CONFIRM;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TSW_IDLE;
            out   <= TSW_OUT_RESET;
        end else begin
            state <= state_nx;
            out   <= out_nx;
        end
    end
endmodule

// File: rtl/toggle_switch_ctrl.sv
module toggle_switch_ctrl
    import toggle_sw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned CONFIRM_TICKS = 100,
    parameter int unsigned BLOCK_TICKS   = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_n,
    output logic sw_on,
    output logic press_event
);
    localparam int unsigned CNT_W = tsw_cnt_width(tsw_max(CONFIRM_TICKS, BLOCK_TICKS));

    logic             btn_n_s;
    logic             pressed_s;
    logic             t_clear;
    logic             t_step;
    logic             t_expire;
    logic [CNT_W-1:0] t_limit;
    tsw_out_t         fsm_out;

    tsw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (btn_n),
        .q   (btn_n_s)
    );

    assign pressed_s = !btn_n_s;

    tsw_interval_timer #(.W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (t_clear),
        .step   (t_step),
        .limit  (t_limit),
        .expire (t_expire)
    );

    tsw_fsm #(
        .W             (CNT_W),
        .CONFIRM_TICKS (CONFIRM_TICKS),
        .BLOCK_TICKS   (BLOCK_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .pressed     (pressed_s),
        .expire      (t_expire),
        .timer_clear (t_clear),
        .timer_step  (t_step),
        .timer_limit (t_limit),
        .out         (fsm_out)
    );

    assign sw_on       = fsm_out.on;
    assign press_event = fsm_out.pulse;
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
    parameter int unsigned CONFIRM_TICKS = 100,
    parameter int unsigned BLOCK_TICKS   = 1000
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic pressed_s,
    input logic sw_on,
    input logic press_event
);
    localparam logic [31:0] MIN_GAP = 32'(BLOCK_TICKS) + 32'(CONFIRM_TICKS);

    logic        seen_event;
    logic [31:0] ticks_since;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_event  <= 1'b0;
            ticks_since <= '0;
        end else if (press_event) begin
            seen_event  <= 1'b1;
            ticks_since <= '0;
        end else if (tick && ticks_since != 32'hFFFF_FFFF) begin
            ticks_since <= ticks_since + 32'd1;
        end
    end

    // R4: output is OFF in the cycle after reset
    p_off_after_reset_r4: assert property (@(posedge clk) $past(rst) |-> (!sw_on && !press_event));

    // R6: pulse lasts one cycle
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst) press_event |=> !press_event);

    // R5: every pulse comes with an inverted output
    p_toggle_on_event_r5: assert property (@(posedge clk) disable iff (rst)
        (press_event && !$past(rst)) |-> (sw_on != $past(sw_on)));

    // R6: without a pulse the output holds
    p_stable_without_event_r6: assert property (@(posedge clk) disable iff (rst)
        (!press_event && !$past(rst)) |-> $stable(sw_on));

    // R2: acceptance follows a strobe that saw the button pressed
    p_confirm_sample_r2: assert property (@(posedge clk) disable iff (rst)
        press_event |-> ($past(tick) && $past(pressed_s)));

    // R3: no acceptance before hold-off plus a new confirmation has elapsed
    p_holdoff_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (press_event && seen_event) |-> (ticks_since >= MIN_GAP));
endmodule

bind toggle_switch_ctrl tsw_checker #(
    .CONFIRM_TICKS (CONFIRM_TICKS),
    .BLOCK_TICKS   (BLOCK_TICKS)
) u_tsw_checker (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .pressed_s   (pressed_s),
    .sw_on       (sw_on),
    .press_event (press_event)
);

// File: tb/toggle_switch_ctrl_bench.sv
module toggle_switch_ctrl_bench;
    localparam int unsigned CONF = 3;
    localparam int unsigned BLK  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic btn_n = 1'b1;
    logic sw_on;
    logic press_event;

    int checks = 0;
    int errors = 0;
    int ev_total = 0;
    int chg_total = 0;
    logic last_on = 1'b0;

    always #5 clk = ~clk;

    toggle_switch_ctrl #(
        .SYNC_STAGES   (2),
        .CONFIRM_TICKS (CONF),
        .BLOCK_TICKS   (BLK)
    ) u_toggle_switch_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .btn_n       (btn_n),
        .sw_on       (sw_on),
        .press_event (press_event)
    );

    // Observe outputs away from the active edge
    always @(negedge clk) begin
        if (press_event) ev_total++;
        if (sw_on !== last_on) chg_total++;
        last_on = sw_on;
    end

    typedef struct packed {
        logic       press;
        logic [7:0] ticks;
        logic       exp_on;
        logic [3:0] exp_ev;
    } vec_t;

    // press level, strobes applied, expected state, expected pulses
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd3, 1'b0, 4'd0},  // idle, released
        '{1'b1, 8'd3, 1'b0, 4'd0},  // R2 still confirming
        '{1'b1, 8'd1, 1'b1, 4'd1},  // R2 confirmed, R5 ON
        '{1'b1, 8'd5, 1'b1, 4'd0},  // R3 hold ignored
        '{1'b0, 8'd2, 1'b1, 4'd0},  // R3 hold-off ends
        '{1'b1, 8'd4, 1'b0, 4'd1},  // R5 second press OFF
        '{1'b0, 8'd2, 1'b0, 4'd0},  // R3 bounce in hold-off
        '{1'b1, 8'd2, 1'b0, 4'd0},  // R3 bounce in hold-off
        '{1'b0, 8'd2, 1'b0, 4'd0},  // R3 hold-off ends
        '{1'b1, 8'd1, 1'b0, 4'd0},  // R7 first sample
        '{1'b0, 8'd3, 1'b0, 4'd0},  // R7 confirm fails
        '{1'b1, 8'd4, 1'b1, 4'd1},  // R7 no hold-off after failure
        '{1'b1, 8'd6, 1'b1, 4'd0},  // R8 hold through hold-off
        '{1'b1, 8'd4, 1'b0, 4'd1},  // R8 held press toggles again
        '{1'b0, 8'd6, 1'b0, 4'd0}   // release, hold-off ends
    };

    task automatic check_eq(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_btn(input logic press);
        @(negedge clk) btn_n = !press;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        int ev0, chg0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4 reset state
        check_eq(sw_on, 0, "R4 sw_on after reset");
        check_eq(press_event, 0, "R4 press_event after reset");

        // R1 long press with no strobe does nothing
        ev0 = ev_total;
        set_btn(1'b1);
        repeat (40) @(negedge clk);
        check_eq(sw_on, 0, "R1 no strobe state");
        check_eq(ev_total - ev0, 0, "R1 no strobe pulses");
        set_btn(1'b0);

        // Table walk: R2 R3 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            ev0  = ev_total;
            chg0 = chg_total;
            set_btn(VECS[v].press);
            for (int t = 0; t < int'(VECS[v].ticks); t++) strobe();
            check_eq(sw_on, VECS[v].exp_on, $sformatf("R2/R3/R5 state vec %0d", v));
            check_eq(ev_total - ev0, VECS[v].exp_ev, $sformatf("R6 pulses vec %0d", v));
            check_eq(chg_total - chg0, VECS[v].exp_ev, $sformatf("R6 toggles vec %0d", v));
        end

        // R1 strobe in the same cycle as the new level sees the old level
        ev0 = ev_total;
        @(negedge clk) begin btn_n = 1'b0; tick = 1'b1; end
        @(negedge clk) tick = 1'b0;
        repeat (2) @(negedge clk);
        for (int t = 0; t < 3; t++) strobe();
        check_eq(sw_on, 0, "R1 synchroniser latency, 4 strobes");
        strobe();
        check_eq(sw_on, 1, "R1 synchroniser latency, 5 strobes");
        check_eq(ev_total - ev0, 1, "R1 pulses after latency");
        set_btn(1'b0);
        for (int t = 0; t < 7; t++) strobe();

        // R4 reset in the middle of a confirmation
        set_btn(1'b1);
        strobe();
        strobe();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq(sw_on, 0, "R4 reset forces OFF");
        check_eq(press_event, 0, "R4 reset clears pulse");
        repeat (3) @(negedge clk);
        for (int t = 0; t < 3; t++) strobe();
        check_eq(sw_on, 0, "R4 confirmation restarted after reset");
        strobe();
        check_eq(sw_on, 1, "R4 press accepted after fresh confirmation");
        set_btn(1'b0);
        for (int t = 0; t < 7; t++) strobe();
        check_eq(sw_on, 1, "R3 release in hold-off keeps ON");

        finish_run();
    end
endmodule